// File: doc/BRIEF.md
# Five-Channel Timer Output Compare with Forced Events

This block holds a 16-bit counter that advances by one on each cycle in which the `tick` input is high. Five compare channels watch the counter. A channel fires when the counter steps onto the value in that channel's compare register. A firing channel applies its pin action to a five-pin output port and raises its status flag. Software can also make any channel fire early. It does this by writing a one to that channel's bit in a force register. A forced firing applies the same pin action but leaves the status flag alone. It takes effect on the next counter step, never in the write cycle.

Channels 2 to 5 each own one port pin. Each has a 2-bit action code: disconnected, toggle, drive low or drive high. Channel 1 can update a group of pins at once. A mask register selects the pins it writes, and a data register gives the levels it writes. Software reaches every register through a byte-wide read/write port with a 5-bit address. Reads return data in the same cycle. Writes take effect at the clock edge.

Top module: `tof_unit`

## Requirements
- R1: The counter resets to 0. It rises by exactly one (wrapping from 0xFFFF to 0) at each edge where `tick` is high, and holds otherwise. It reads at address 6 (high byte) and address 7 (low byte).
- R2: A channel fires at the tick edge where the counter moves onto its compare value. At that same edge the pin action is applied and the channel's flag is set. Flags read at address 4, with channel 1 in bit 7 down to channel 5 in bit 3.
- R3: The force register is at address 0, with channel 1 in bit 7 down to channel 5 in bit 3. Writing a 1 requests a forced firing of that channel. Writing a 0 requests nothing. The register always reads 0. A request is used once, at the next tick, and then dropped.
- R4: A forced firing changes no pin before the next tick edge. A write made in a cycle where `tick` is already high waits for the following tick. A forced firing never sets a flag.
- R5: When a real match and a force request land on the same tick, the action runs once and the flag is set. A toggling channel therefore flips only once.
- R6: The action register is at address 3. Channel 2 uses bits 7:6, channel 3 bits 5:4, channel 4 bits 3:2 and channel 5 bits 1:0. The codes are 00 none, 01 toggle, 10 low and 11 high. Channel k drives port pin 8-k, which is `pins` bit 5-k.
- R7: When channel 1 fires, each pin enabled in the mask register (address 1, bits 7:3 for pins 7:3) takes the level of the matching bit of the data register (address 2). Pins not enabled in the mask keep their level. Channel 1 sets no pin of its own.
- R8: When channel 1 and another channel act on the same pin at the same tick, the level from channel 1 wins.
- R9: Writing a 1 to a flag bit clears it, and writing a 0 leaves it. A new match on the same edge as a clear leaves the flag set.
- R10: After reset, the force, mask, data, action and flag registers and the pins are 0. Every compare register is 0xFFFF. Channel c (1..5) has its compare register at address 8+2(c-1) for the high byte and the next address for the low byte.
- R11: Bits 2:0 of the mask, data and flag registers read as 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advance enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pins | output | 5 | Port pins 7 down to 3 (bit 4 is pin 7) |

## Verification
The assertions take for granted that `tick` is the only source of pin and flag changes. They also assume that a flag clear through the bus is not expected to win against a match on the same edge. The stimulus drives the bus and `tick` only on falling clock edges, and keeps `bus_we` high for one cycle per write. Compare values are always loaded with `tick` low, so a half-written compare register is never checked against the counter. The one write made during a tick is the deliberate case covered by R4.

// File: rtl/tof_pkg.sv
package tof_pkg;
    localparam int NCH    = 5;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 5;
    localparam int DW     = 8;

    localparam logic [ADDR_W-1:0] A_FORCE = 5'd0;
    localparam logic [ADDR_W-1:0] A_MASK  = 5'd1;
    localparam logic [ADDR_W-1:0] A_DATA  = 5'd2;
    localparam logic [ADDR_W-1:0] A_ACT   = 5'd3;
    localparam logic [ADDR_W-1:0] A_FLAG  = 5'd4;
    localparam logic [ADDR_W-1:0] A_CNTH  = 5'd6;
    localparam logic [ADDR_W-1:0] A_CNTL  = 5'd7;
    localparam logic [ADDR_W-1:0] A_CMP0  = 5'd8;

    typedef enum logic [1:0] {
        ACT_OFF  = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } act_e;
endpackage

// File: rtl/tof_counter.sv
module tof_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d;

    assign cnt_nxt = cnt_q + ONE;

    always_comb begin
        cnt_d = cnt_q;
        if (tick) begin
            cnt_d = cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + ONE)); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/tof_match.sv
module tof_match #(
    parameter int NCH = 5,
    parameter int W   = 16
) (
    input  logic                  tick,
    input  logic [W-1:0]          cnt_nxt,
    input  logic [NCH-1:0][W-1:0] cmp,
    output logic [NCH-1:0]        hit
);
    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign hit[g] = tick && (cnt_nxt == cmp[g]);
    end
endmodule

// File: rtl/tof_pin_ctrl.sv
module tof_pin_ctrl
    import tof_pkg::*;
#(
    parameter int NCH = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ev,
    input  logic [NCH-2:0][1:0]   act,
    input  logic [NCH-1:0]        mask,
    input  logic [NCH-1:0]        data,
    output logic [NCH-1:0]        pins_q
);
    localparam int GRP = NCH - 1;

    logic [NCH-1:0] pins_d;

    always_comb begin
        pins_d = pins_q;
        for (int i = 0; i < NCH - 1; i++) begin
            if (ev[i]) begin
                case (act_e'(act[i]))
                    ACT_TOG:  pins_d[i] = ~pins_q[i];
                    ACT_LOW:  pins_d[i] = 1'b0;
                    ACT_HIGH: pins_d[i] = 1'b1;
                    default:  pins_d[i] = pins_q[i];
                endcase
            end
        end
        if (ev[GRP]) begin
            pins_d = (pins_d & ~mask) | (data & mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else begin
            pins_q <= pins_d;
        end
    end

    AST_GROUP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev[GRP] |=> (((pins_q ^ $past(data)) & $past(mask)) == '0)); // R8
    AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == '0) |=> $stable(pins_q)); // R4

    for (genvar g = 0; g < NCH - 1; g++) begin : g_chk
        AST_TOGGLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[g] && act[g] == ACT_TOG && !(ev[GRP] && mask[g]))
            |=> (pins_q[g] != $past(pins_q[g]))); // R5
    end
endmodule

// File: rtl/tof_unit.sv
module tof_unit
    import tof_pkg::*;
#(
    parameter int NCH    = tof_pkg::NCH,
    parameter int CNT_W  = tof_pkg::CNT_W,
    parameter int ADDR_W = tof_pkg::ADDR_W,
    parameter int DW     = tof_pkg::DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    pins
);
    localparam int LOW = DW - NCH;
    localparam int AW  = 2 * (NCH - 1);

    typedef struct packed {
        logic [NCH-1:0]            pend;
        logic [NCH-1:0]            mask;
        logic [NCH-1:0]            data;
        logic [NCH-2:0][1:0]       act;
        logic [NCH-1:0]            flag;
        logic [NCH-1:0][CNT_W-1:0] cmp;
    } st_t;

    st_t s_d, s_q;

    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic [NCH-1:0]   hit;
    logic [NCH-1:0]   ev;
    logic [NCH-1:0]   wv;
    logic             wr_force, wr_flag;

    tof_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    tof_match #(.NCH(NCH), .W(CNT_W)) u_match (
        .tick    (tick),
        .cnt_nxt (cnt_nxt),
        .cmp     (s_q.cmp),
        .hit     (hit)
    );

    tof_pin_ctrl #(.NCH(NCH)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .act    (s_q.act),
        .mask   (s_q.mask),
        .data   (s_q.data),
        .pins_q (pins)
    );

    assign wv       = bus_wdata[DW-1:LOW];
    assign wr_force = bus_we && (bus_addr == A_FORCE);
    assign wr_flag  = bus_we && (bus_addr == A_FLAG);
    assign ev       = tick ? (hit | s_q.pend) : '0;

    always_comb begin
        s_d = s_q;
        s_d.pend = (tick ? '0 : s_q.pend) | (wr_force ? wv : '0);
        s_d.flag = (s_q.flag & ~(wr_flag ? wv : '0)) | hit;
        if (bus_we) begin
            case (bus_addr)
                A_MASK:  s_d.mask = wv;
                A_DATA:  s_d.data = wv;
                A_ACT:   s_d.act  = bus_wdata[AW-1:0];
                default: ;
            endcase
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == ADDR_W'(A_CMP0 + 2 * c)) begin
                    s_d.cmp[NCH-1-c][CNT_W-1:DW] = bus_wdata;
                end
                if (bus_addr == ADDR_W'(A_CMP0 + 2 * c + 1)) begin
                    s_d.cmp[NCH-1-c][DW-1:0] = bus_wdata;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MASK:  bus_rdata = {s_q.mask, {LOW{1'b0}}};
            A_DATA:  bus_rdata = {s_q.data, {LOW{1'b0}}};
            A_ACT:   bus_rdata = s_q.act;
            A_FLAG:  bus_rdata = {s_q.flag, {LOW{1'b0}}};
            A_CNTH:  bus_rdata = cnt_q[CNT_W-1:DW];
            A_CNTL:  bus_rdata = cnt_q[DW-1:0];
            default: ;
        endcase
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == ADDR_W'(A_CMP0 + 2 * c)) begin
                bus_rdata = s_q.cmp[NCH-1-c][CNT_W-1:DW];
            end
            if (bus_addr == ADDR_W'(A_CMP0 + 2 * c + 1)) begin
                bus_rdata = s_q.cmp[NCH-1-c][DW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cmp <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((s_q.flag & $past(hit)) == $past(hit))); // R2
    AST_FLAG_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.flag & ~$past(s_q.flag) & ~$past(hit)) == '0)); // R4
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && hit == '0) |=> ((s_q.flag & $past(wv)) == '0)); // R9
endmodule

// File: tb/tof_unit_tb.sv
`timescale 1ns/1ps
module tof_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] pins;

    int   nchk = 0;
    int   nerr = 0;
    logic [15:0] bcnt = '0;

    always #10 clk = ~clk;

    tof_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins      (pins)
    );

    task automatic chk(input string req, input int actv, input int expv);
        nchk++;
        if (actv != expv) begin
            nerr++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, actv, expv);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
        bcnt = bcnt + 16'(n);
    endtask

    task automatic set_cmp(input int ch, input logic [15:0] v);
        wr(5'(8 + 2 * (ch - 1)), v[15:8]);
        wr(5'(9 + 2 * (ch - 1)), v[7:0]);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(0, d); chk("R10 force", d, 0);
        rd(1, d); chk("R10 mask", d, 0);
        rd(4, d); chk("R10 flags", d, 0);
        rd(3, d); chk("R10 action", d, 0);
        rd(12, d); chk("R10 cmp3 hi", d, 8'hFF);
        rd(13, d); chk("R10 cmp3 lo", d, 8'hFF);
        chk("R10 pins", pins, 0);
    endtask

    task automatic t_count;
        logic [7:0] d;
        ticks(5);
        repeat (3) @(negedge clk);
        rd(7, d); chk("R1 count lo", d, 5);
        rd(6, d); chk("R1 count hi", d, 0);
    endtask

    task automatic t_real_match;
        logic [7:0] d;
        wr(3, 8'hC0);
        set_cmp(2, bcnt + 16'd3);
        ticks(2);
        chk("R2 before match pins", pins, 5'b00000);
        rd(4, d); chk("R2 before match flags", d, 0);
        ticks(1);
        chk("R6 ch2 high on pin6", pins, 5'b01000);
        rd(4, d); chk("R2 flag ch2", d, 8'h40);
    endtask

    task automatic t_w1c;
        logic [7:0] d;
        wr(4, 8'h00);
        rd(4, d); chk("R9 write zero keeps", d, 8'h40);
        wr(4, 8'h40);
        rd(4, d); chk("R9 write one clears", d, 8'h00);
    endtask

    task automatic t_force;
        logic [7:0] d;
        wr(3, 8'h30);
        wr(0, 8'h20);
        rd(0, d); chk("R3 force reads zero", d, 0);
        repeat (2) @(negedge clk);
        chk("R4 no action before tick", pins, 5'b01000);
        ticks(1);
        chk("R4 forced ch3 high", pins, 5'b01100);
        rd(4, d); chk("R4 forced no flag", d, 0);
        wr(3, 8'h10);
        ticks(1);
        chk("R3 request used once", pins, 5'b01100);
        wr(0, 8'h00);
        ticks(1);
        chk("R3 zero write no action", pins, 5'b01100);
    endtask

    task automatic t_same_tick;
        logic [7:0] d;
        wr(3, 8'h04);
        set_cmp(4, bcnt + 16'd1);
        wr(0, 8'h10);
        ticks(1);
        chk("R5 toggle once", pins, 5'b01110);
        rd(4, d); chk("R5 flag set", d, 8'h10);
        wr(4, 8'hF8);
    endtask

    task automatic t_group;
        logic [7:0] d;
        wr(3, 8'h00);
        wr(1, 8'hA8);
        wr(2, 8'hD0);
        wr(0, 8'h80);
        ticks(1);
        chk("R7 masked pins follow data", pins, 5'b11010);
        rd(4, d); chk("R7 forced ch1 no flag", d, 0);
        rd(2, d); chk("R11 data low bits", d, 8'hD0);
    endtask

    task automatic t_priority;
        logic [7:0] d;
        wr(3, 8'h03);
        wr(1, 8'h0F);
        rd(1, d); chk("R11 mask low bits", d, 8'h08);
        wr(2, 8'h00);
        wr(0, 8'h88);
        ticks(1);
        chk("R8 ch1 beats ch5", pins, 5'b11010);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'd0; bus_wdata = 8'h08; tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0;
        bcnt = bcnt + 16'd1;
        chk("R4 write during tick waits", pins, 5'b11010);
        ticks(1);
        chk("R4 applied next tick", pins, 5'b11011);
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        wr(4, 8'hF8);
        ticks(65536);
        rd(6, d); chk("R1 wrap hi", d, int'(bcnt[15:8]));
        rd(7, d); chk("R1 wrap lo", d, int'(bcnt[7:0]));
        rd(4, d); chk("R2 all flags after full cycle", d, 8'hF8);
        chk("R8 ch1 wins at shared match", pins, 5'b11010);
    endtask

    initial begin
        #3_000_000;
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_real_match();
        t_w1c();
        t_force();
        t_same_tick();
        t_group();
        t_priority();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule